// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block decides which pending DRAM request goes next. A queue of candidate requests is presented on its inputs. Each request has a valid bit, a bank index, a row index and an age, where a larger age means the request has waited longer. The block keeps a table that records, for every bank, whether a row is open, which row it is, and how many accesses that row has served since it was opened. From that table and the candidates it produces the index of the chosen request, a flag that says whether the choice hits the open row of its bank, and a hint that the row should be closed after this access.

There are two policies, chosen at run time. The default policy prefers row hits: it serves the oldest request that hits an open row and falls back to the oldest request overall when no request hits. The other policy is strict oldest-first. Open rows cannot starve other traffic. When a row has served a capped number of accesses, the access that reaches the cap raises the close hint and the bank is recorded as closed, so later requests to that row count as misses.

The table changes only when the surrounding controller asserts `issue_en` while a choice is valid. A miss that is issued opens its row with a count of one. A hit that is issued adds one to the count. The queue size (32 by default), the bank count (8), the row and age widths and the access cap (16) are parameters.

Top module: `row_hit_sched`

## Requirements
- R1: `pick_vld` is 0 when no candidate is valid. It is 1 when at least one candidate is valid, and `pick_idx` then names a valid candidate. When `pick_vld` is 0, `pick_hit` and `pick_close` are 0.
- R2: When `fcfs_mode` is 1, `pick_idx` is the valid candidate with the largest age. If several candidates share that age, the lowest index wins.
- R3: When `fcfs_mode` is 0 and at least one valid candidate hits, `pick_idx` is the hitting candidate with the largest age. If several share that age, the lowest index wins.
- R4: When `fcfs_mode` is 0 and no valid candidate hits, `pick_idx` is the valid candidate with the largest age. If several share that age, the lowest index wins.
- R5: A candidate hits when its bank has an open row and that row equals the candidate's row. `pick_hit` tells whether the chosen candidate hits. After reset every bank is closed.
- R6: An issued miss opens the candidate's row in its bank with an access count of 1. An issued hit adds one to the bank's count. Either change is visible from the next cycle on.
- R7: `pick_close` is 1 when issuing the choice would bring its bank's count to the cap (for a hit, count+1 is at least CAP; for a miss, CAP is 1). Issuing such a choice closes the bank, so the next request to the same row is a miss.
- R8: When `issue_en` is 0, or `pick_vld` is 0, the bank table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; closes every bank |
| fcfs_mode | input | 1 | 1 = strict oldest-first, 0 = row-hit-first |
| issue_en | input | 1 | The current choice is issued this cycle |
| req_vld | input | ENTRIES | Valid bit for each candidate |
| req_bank | input | ENTRIES*log2(BANKS) | Bank index of each candidate, packed with entry i at bits i*BW |
| req_row | input | ENTRIES*ROW_W | Row index of each candidate, packed with entry i at bits i*ROW_W |
| req_age | input | ENTRIES*AGE_W | Age of each candidate; a larger value is older |
| pick_vld | output | 1 | A candidate is chosen |
| pick_idx | output | log2(ENTRIES) | Index of the chosen candidate |
| pick_hit | output | 1 | The chosen candidate hits its bank's open row |
| pick_close | output | 1 | Issuing the choice reaches the access cap; close the row |

## Verification
The assertions check on every cycle that a reported choice is a valid entry, that a hit is always taken in row-hit-first mode whenever one exists, and that no open row's count has reached the cap. They also check that the table stays unchanged without an issue, and that issued misses and cap-reaching hits leave the bank in the right state. The age ordering cannot be checked by the assertions, because it needs a search over all entries. The same holds for the lowest-index tie break and the full sequence of a row from opening through its capped close to reopening. The bench shows these by comparing every cycle against a behavioural model, running directed sequences and a long stretch of mixed traffic with switches between the two policies.

// File: rtl/sched_pkg.sv
package sched_pkg;
   typedef enum logic {
      POL_ROWHIT = 1'b0,
      POL_FCFS   = 1'b1
   } sched_pol_e;
endpackage

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
   parameter int ENTRIES = 32,
   parameter int AGE_W   = 8,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]       cand,
   input  logic [ENTRIES*AGE_W-1:0] age,
   output logic                     found,
   output logic [IW-1:0]            idx
);
   logic [AGE_W-1:0] best;

   // linear scan: strict compare keeps the lowest index among equal ages
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (cand[i] && (!found || age[i*AGE_W +: AGE_W] > best)) begin
            found = 1'b1;
            idx   = IW'(i);
            best  = age[i*AGE_W +: AGE_W];
         end
      end
   end
endmodule

// File: rtl/sched_hit_detect.sv
module sched_hit_detect #(
   parameter int ENTRIES = 32,
   parameter int BANKS   = 8,
   parameter int ROW_W   = 14,
   localparam int BW     = $clog2(BANKS)
) (
   input  logic [ENTRIES-1:0]       req_vld,
   input  logic [ENTRIES*BW-1:0]    req_bank,
   input  logic [ENTRIES*ROW_W-1:0] req_row,
   input  logic [BANKS-1:0]         open_vld,
   input  logic [BANKS*ROW_W-1:0]   open_row,
   output logic [ENTRIES-1:0]       hit
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [BW-1:0] bk;
      assign bk     = req_bank[g*BW +: BW];
      assign hit[g] = req_vld[g] && open_vld[bk] &&
                      (open_row[bk*ROW_W +: ROW_W] == req_row[g*ROW_W +: ROW_W]);
   end
endmodule

// File: rtl/sched_bank_table.sv
module sched_bank_table #(
   parameter int BANKS = 8,
   parameter int ROW_W = 14,
   parameter int CAP   = 16,
   localparam int BW   = $clog2(BANKS),
   localparam int CW   = $clog2(CAP + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd,
   input  logic [BW-1:0]          upd_bank,
   input  logic [ROW_W-1:0]       upd_row,
   input  logic                   upd_hit,
   output logic [BANKS-1:0]       open_vld,
   output logic [BANKS*ROW_W-1:0] open_row,
   output logic [BANKS*CW-1:0]    open_cnt
);
   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic             vld_q;
      logic [ROW_W-1:0] row_q;
      logic [CW-1:0]    cnt_q;
      logic [CW:0]      cnt_inc;
      logic             sel;

      assign sel     = upd && (upd_bank == BW'(b));
      assign cnt_inc = {1'b0, cnt_q} + 1'b1;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            row_q <= '0;
            cnt_q <= '0;
         end else if (sel) begin
            if (upd_hit) begin
               cnt_q <= cnt_inc[CW-1:0];
               if (cnt_inc >= (CW+1)'(CAP)) vld_q <= 1'b0;
            end else begin
               vld_q <= (CAP > 1);
               row_q <= upd_row;
               cnt_q <= CW'(1);
            end
         end
      end

      assign open_vld[b]                 = vld_q;
      assign open_row[b*ROW_W +: ROW_W]  = row_q;
      assign open_cnt[b*CW +: CW]        = cnt_q;

      // an open row never sits at or above the cap
      assert_cnt_below_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
         vld_q |-> (cnt_q < CW'(CAP)));
   end

   // table frozen without an update
   assert_table_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(open_vld) && $stable(open_row) && $stable(open_cnt)));

   // an issued miss opens its row with a count of one
   if (CAP > 1) begin : g_open_chk
      assert_miss_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (upd && !upd_hit) |=> (open_vld[$past(upd_bank)] &&
            open_row[$past(upd_bank)*ROW_W +: ROW_W] == $past(upd_row) &&
            open_cnt[$past(upd_bank)*CW +: CW] == CW'(1)));
   end
endmodule

// File: rtl/row_hit_sched.sv
module row_hit_sched #(
   parameter int ENTRIES = 32,
   parameter int BANKS   = 8,
   parameter int ROW_W   = 14,
   parameter int AGE_W   = 8,
   parameter int CAP     = 16,
   localparam int IW     = $clog2(ENTRIES),
   localparam int BW     = $clog2(BANKS),
   localparam int CW     = $clog2(CAP + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fcfs_mode,
   input  logic                     issue_en,
   input  logic [ENTRIES-1:0]       req_vld,
   input  logic [ENTRIES*BW-1:0]    req_bank,
   input  logic [ENTRIES*ROW_W-1:0] req_row,
   input  logic [ENTRIES*AGE_W-1:0] req_age,
   output logic                     pick_vld,
   output logic [IW-1:0]            pick_idx,
   output logic                     pick_hit,
   output logic                     pick_close
);
   import sched_pkg::*;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("row_hit_sched: ENTRIES must be at least 2");
   end
   if (BANKS < 2 || (1 << BW) != BANKS) begin : g_bad_banks
      $error("row_hit_sched: BANKS must be a power of two of at least 2");
   end
   if (CAP < 1) begin : g_bad_cap
      $error("row_hit_sched: CAP must be at least 1");
   end

   sched_pol_e pol;
   assign pol = sched_pol_e'(fcfs_mode);

   logic [BANKS-1:0]       open_vld;
   logic [BANKS*ROW_W-1:0] open_row;
   logic [BANKS*CW-1:0]    open_cnt;
   logic [ENTRIES-1:0]     hit_vec;
   logic                   hit_found, any_found;
   logic [IW-1:0]          hit_idx, any_idx;

   sched_hit_detect #(.ENTRIES(ENTRIES), .BANKS(BANKS), .ROW_W(ROW_W)) u_hit (
      .req_vld(req_vld), .req_bank(req_bank), .req_row(req_row),
      .open_vld(open_vld), .open_row(open_row), .hit(hit_vec));

   sched_age_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_pick_hit (
      .cand(hit_vec), .age(req_age), .found(hit_found), .idx(hit_idx));

   sched_age_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_pick_any (
      .cand(req_vld), .age(req_age), .found(any_found), .idx(any_idx));

   logic [BW-1:0]    sel_bank;
   logic [ROW_W-1:0] sel_row;
   logic [CW-1:0]    sel_cnt;
   logic [CW:0]      sel_inc;

   assign pick_vld = any_found;
   assign pick_idx = (pol == POL_ROWHIT && hit_found) ? hit_idx : any_idx;
   assign sel_bank = req_bank[pick_idx*BW +: BW];
   assign sel_row  = req_row[pick_idx*ROW_W +: ROW_W];
   assign sel_cnt  = open_cnt[sel_bank*CW +: CW];
   assign sel_inc  = {1'b0, sel_cnt} + 1'b1;
   assign pick_hit = pick_vld && hit_vec[pick_idx];
   assign pick_close = pick_vld &&
                       (pick_hit ? (sel_inc >= (CW+1)'(CAP)) : (CAP == 1));

   sched_bank_table #(.BANKS(BANKS), .ROW_W(ROW_W), .CAP(CAP)) u_table (
      .clk(clk), .rst_n(rst_n), .upd(issue_en && pick_vld),
      .upd_bank(sel_bank), .upd_row(sel_row), .upd_hit(pick_hit),
      .open_vld(open_vld), .open_row(open_row), .open_cnt(open_cnt));

   assert_pick_is_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pick_vld |-> req_vld[pick_idx]);
   assert_pick_when_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_vld) |-> pick_vld);
   assert_hit_preferred_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fcfs_mode && (|hit_vec)) |-> pick_hit);
   assert_close_shuts_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_en && pick_close) |=> !open_vld[$past(sel_bank)]);
endmodule

// File: tb/row_hit_sched_bench.sv
module row_hit_sched_bench;
   localparam int N   = 32;
   localparam int NB  = 8;
   localparam int RW  = 14;
   localparam int AW  = 8;
   localparam int CAP = 16;
   localparam int IW  = $clog2(N);
   localparam int BW  = $clog2(NB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fcfs_mode = 1'b0;
   logic issue_en = 1'b0;
   logic [N-1:0]    req_vld;
   logic [N*BW-1:0] req_bank;
   logic [N*RW-1:0] req_row;
   logic [N*AW-1:0] req_age;
   logic            pick_vld, pick_hit, pick_close;
   logic [IW-1:0]   pick_idx;

   always #4 clk = ~clk;

   bit ev [N];
   int eb [N];
   int er [N];
   int ea [N];

   always_comb begin
      for (int i = 0; i < N; i++) begin
         req_vld[i]             = ev[i];
         req_bank[i*BW +: BW]   = BW'(eb[i]);
         req_row[i*RW +: RW]    = RW'(er[i]);
         req_age[i*AW +: AW]    = AW'(ea[i]);
      end
   end

   row_hit_sched #(.ENTRIES(N), .BANKS(NB), .ROW_W(RW), .AGE_W(AW), .CAP(CAP))
   u_row_hit_sched (
      .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode), .issue_en(issue_en),
      .req_vld(req_vld), .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
      .pick_vld(pick_vld), .pick_idx(pick_idx), .pick_hit(pick_hit),
      .pick_close(pick_close));

   // behavioural model state
   bit m_open [NB];
   int m_row  [NB];
   int m_cnt  [NB];
   int x_vld, x_idx, x_hit, x_close;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   task automatic cmp(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_hits(int i);
      return ev[i] && m_open[eb[i]] && (m_row[eb[i]] == er[i]);
   endfunction

   // sample mid-cycle and compare against the model
   task automatic eval();
      int bh, ba;
      string itag;
      #3;
      bh = -1; ba = -1;
      for (int i = 0; i < N; i++) begin
         if (ev[i]) begin
            if (m_hits(i) && (bh < 0 || ea[i] > ea[bh])) bh = i;
            if (ba < 0 || ea[i] > ea[ba]) ba = i;
         end
      end
      x_vld   = (ba >= 0);
      x_idx   = (!fcfs_mode && bh >= 0) ? bh : ba;
      x_hit   = x_vld ? int'(m_hits(x_idx)) : 0;
      x_close = !x_vld ? 0 : (x_hit != 0) ? int'(m_cnt[eb[x_idx]] + 1 >= CAP) : int'(CAP == 1);
      itag = fcfs_mode ? "R2 oldest-first index" :
             (bh >= 0) ? "R3 oldest-hit index" : "R4 oldest-miss index";
      cmp("R1 pick_vld", int'(pick_vld), x_vld);
      if (x_vld != 0) cmp(itag, int'(pick_idx), x_idx);
      cmp("R5 pick_hit", int'(pick_hit), x_hit);
      cmp("R7 pick_close", int'(pick_close), x_close);
   endtask

   // apply the issue decision to the model, then move to the next cycle
   task automatic adv();
      if (issue_en && x_vld != 0) begin
         if (x_hit != 0) begin
            m_cnt[eb[x_idx]]++;
            if (m_cnt[eb[x_idx]] >= CAP) m_open[eb[x_idx]] = 0;
         end else begin
            m_open[eb[x_idx]] = (CAP > 1);
            m_row[eb[x_idx]]  = er[x_idx];
            m_cnt[eb[x_idx]]  = 1;
         end
      end
      @(posedge clk);
      #1;
   endtask

   task automatic clear_all();
      for (int i = 0; i < N; i++) begin
         ev[i] = 0; eb[i] = 0; er[i] = 0; ea[i] = 0;
      end
   endtask

   task automatic set_ent(int i, int b, int r, int a);
      ev[i] = 1; eb[i] = b; er[i] = r; ea[i] = a;
   endtask

   initial begin
      clear_all();
      for (int b = 0; b < NB; b++) begin
         m_open[b] = 0; m_row[b] = 0; m_cnt[b] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state: nothing pending, then row 0 of bank 0 is not open
      eval();
      cmp("R1 reset idle pick_vld", int'(pick_vld), 0);
      adv();
      set_ent(0, 0, 0, 1);
      eval();
      cmp("R5 reset banks closed", int'(pick_hit), 0);
      adv();

      // no issue: table must not move
      clear_all();
      set_ent(3, 2, 5, 10);
      for (int k = 0; k < 4; k++) begin
         eval();
         cmp("R8 no issue keeps miss", int'(pick_hit), 0);
         adv();
      end

      // issue the miss, row opens with count 1
      issue_en = 1'b1;
      eval();
      adv();
      issue_en = 1'b0;
      eval();
      cmp("R6 opened row now hits", int'(pick_hit), 1);
      adv();

      // hit wins over an older miss; ties go to the lowest index
      set_ent(7, 4, 9, 200);
      set_ent(9, 2, 5, 10);
      eval();
      cmp("R3 hit over older miss", int'(pick_idx), 3);
      fcfs_mode = 1'b1;
      adv();
      eval();
      cmp("R2 oldest-first ignores hit", int'(pick_idx), 7);
      fcfs_mode = 1'b0;
      adv();

      // drive bank 2 row 5 to the cap
      clear_all();
      set_ent(3, 2, 5, 10);
      issue_en = 1'b1;
      for (int k = 0; k < CAP - 2; k++) begin
         eval();
         adv();
      end
      eval();
      cmp("R7 close at cap", int'(pick_close), 1);
      adv();
      issue_en = 1'b0;
      eval();
      cmp("R7 capped row is a miss", int'(pick_hit), 0);
      adv();

      // mixed traffic
      for (int c = 0; c < 4000; c++) begin
         int dens;
         if (c % 150 == 0) fcfs_mode = ~fcfs_mode;
         dens = (c / 50) % 4;
         for (int i = 0; i < N; i++) begin
            ev[i] = (dens != 0) && (($urandom % 4) < dens);
            eb[i] = int'($urandom % NB);
            er[i] = int'($urandom % 3);
            ea[i] = int'($urandom % 16);
         end
         issue_en = ($urandom % 3) != 0;
         eval();
         adv();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule